// File: doc/BRIEF.md
# Effective-to-Physical Address Translator with Block Override

This block converts a 32-bit effective address into a 32-bit physical address for one access stream. Each request goes to two structures at once. The first is a small fully associative page TLB with 4 KB pages. The second is an array of block-translation entries that cover larger aligned regions. When both structures match, the block entry supplies the translation. The block then checks the access against the privilege of the requester and against its direction (load or store). The result is a hit with a physical address, a protection fault, or a miss.

The block never fills the TLB by itself. When neither structure matches, it records the effective address in a miss register and raises a flag. Software reads that register, walks its page tables, and writes the translation back through the TLB load port. Block entries are programmed through a separate indexed write port. Every lookup takes one cycle from request to registered response.

Top module: `xlat_unit`

## Requirements
- R1: On a page-TLB hit that the block array does not override, rsp_pa is {ppn, req_ea[11:0]}. Bits [31:12] are translated and bits [11:0] pass through unchanged.
- R2: A block entry holds a 15-bit effective tag, a 15-bit physical tag and a 15-bit mask that cover address bits [31:17]. A mask bit set to 1 excludes that bit from the compare and passes the matching effective-address bit to the physical address. A block hit gives rsp_pa[31:17] = (pa_tag & ~mask) | (ea[31:17] & mask) and rsp_pa[16:0] = ea[16:0]. A write to block index i takes effect on the next cycle.
- R3: When the block array and the page TLB both match, the block translation is used and rsp_blk is 1. When more than one block entry matches, the lowest index wins.
- R4: A block entry matches a supervisor access (req_super=1) only when its supervisor-valid bit is set. It matches a user access only when its user-valid bit is set. A user access to a supervisor-only region falls through to the page TLB.
- R5: A load needs the entry's read bit and a store needs its write bit. A denied access sets rsp_fault, and rsp_pa is 0 on every fault or miss.
- R6: A TLB entry whose key bit is set faults on any user access, whatever its read and write bits. Supervisor accesses to that entry are unaffected by the key bit.
- R7: When neither structure matches, the response is rsp_miss. On the same cycle miss_flag becomes 1 and miss_ea takes the missing effective address.
- R8: A block match that denies the access reports a fault and not a miss, even if the TLB would have allowed the access. The miss register is left unchanged.
- R9: miss_ea changes only on a new miss. miss_flag clears on miss_clr or on a TLB load. A miss in the same cycle as a clear leaves the flag set.
- R10: rsp_valid is req_valid delayed by one cycle. When rsp_valid is 1, exactly one of rsp_hit, rsp_miss and rsp_fault is 1.
- R11: A TLB load whose page number is already present overwrites that entry, and the replacement pointer does not move. Any other load fills the slot under a round-robin pointer over 8 entries. The ninth distinct load therefore evicts the first.
- R12: After reset all TLB and block entries are invalid. rsp_valid, miss_flag and miss_ea are 0, and the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_pa | output | 32 | Physical address (0 unless hit) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No translation found |
| rsp_fault | output | 1 | Protection fault |
| rsp_blk | output | 1 | Hit came from the block array |
| miss_flag | output | 1 | A miss is pending for software |
| miss_ea | output | 32 | Last missing effective address |
| miss_clr | input | 1 | Clear the pending-miss flag |
| tlb_ld_en | input | 1 | Load one TLB entry |
| tlb_ld_vpn | input | 20 | Virtual page number to load |
| tlb_ld_ppn | input | 20 | Physical page number to load |
| tlb_ld_rd | input | 1 | Read permitted |
| tlb_ld_wr | input | 1 | Write permitted |
| tlb_ld_key | input | 1 | Deny all user accesses |
| blk_wr_en | input | 1 | Write one block entry |
| blk_wr_idx | input | 2 | Block entry index |
| blk_wr_ea_tag | input | 15 | Effective tag, bits [31:17] |
| blk_wr_pa_tag | input | 15 | Physical tag, bits [31:17] |
| blk_wr_mask | input | 15 | Compare mask (1 = don't care) |
| blk_wr_sv | input | 1 | Valid for supervisor |
| blk_wr_uv | input | 1 | Valid for user |
| blk_wr_rd | input | 1 | Read permitted |
| blk_wr_wr | input | 1 | Write permitted |

## Verification
The lookup path is tried with address patterns that each separate one source of the answer. Some addresses hit only the page TLB and check the pass-through of the page offset. Some fall inside a masked block, where the masked bit shows that the block merges effective and physical tag bits. Others hit both structures, to show which one wins. The same addresses are issued with different privilege and direction. This tells the key-bit fault apart from the write-permission fault, and a user fall-through on a supervisor-only block apart from a real block hit. A denied block write on a page the TLB would allow shows that the fault takes priority over the TLB and over a miss. Directed sequences then check three things: round-robin eviction after eight loads, the in-place reload of an existing page, and a miss racing a clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int EA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int VPN_W   = EA_W - PG_BITS;
    localparam int BLK_LO  = 17;
    localparam int BTAG_W  = EA_W - BLK_LO;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic             rd;
        logic             wr;
        logic             ukey;
    } tlb_ent_t;

    typedef struct packed {
        logic              sv;
        logic              uv;
        logic [BTAG_W-1:0] ea_tag;
        logic [BTAG_W-1:0] pa_tag;
        logic [BTAG_W-1:0] mask;
        logic              rd;
        logic              wr;
    } blk_ent_t;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [VPN_W-1:0] lk_ppn,
    output logic             lk_rd,
    output logic             lk_wr,
    output logic             lk_ukey,
    input  logic             ld_en,
    input  tlb_ent_t         ld_ent
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    typedef struct packed {
        tlb_ent_t [N-1:0] ent;
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] hv;
    logic [N-1:0] mv;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign hv[gi] = st_q.ent[gi].valid && (st_q.ent[gi].vpn == lk_vpn);
        assign mv[gi] = st_q.ent[gi].valid && (st_q.ent[gi].vpn == ld_ent.vpn);
    end

    always_comb begin
        lk_hit  = |hv;
        lk_ppn  = '0;
        lk_rd   = 1'b0;
        lk_wr   = 1'b0;
        lk_ukey = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hv[i]) begin
                lk_ppn  = lk_ppn | st_q.ent[i].ppn;
                lk_rd   = lk_rd | st_q.ent[i].rd;
                lk_wr   = lk_wr | st_q.ent[i].wr;
                lk_ukey = lk_ukey | st_q.ent[i].ukey;
            end
        end
    end

    logic [PTR_W-1:0] slot;

    always_comb begin
        st_d = st_q;
        slot = st_q.ptr;
        if (ld_en) begin
            if (|mv) begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (mv[i]) slot = PTR_W'(i);
                end
            end else begin
                st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
            end
            st_d.ent[slot]       = ld_ent;
            st_d.ent[slot].valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: the loader never leaves two valid entries with one page number
    p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hv));

    // R11: a load of a new page advances the pointer by one, with wrap
    p_rr_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !(|mv)) |=>
            (st_q.ptr == (($past(st_q.ptr) == LAST) ? '0 : $past(st_q.ptr) + 1'b1)));

    // R11: reloading a present page keeps the pointer
    p_inplace_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (|mv)) |=> $stable(st_q.ptr));
endmodule

// File: rtl/xlat_bat.sv
module xlat_bat
    import xlat_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  blk_ent_t          wr_ent,
    input  logic [BTAG_W-1:0] lk_tag,
    input  logic              lk_super,
    output logic              lk_hit,
    output logic [BTAG_W-1:0] lk_pa_tag,
    output logic              lk_rd,
    output logic              lk_wr
);
    typedef struct packed {
        blk_ent_t [N-1:0] ent;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] hv;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign hv[gi] = (((st_q.ent[gi].ea_tag ^ lk_tag) & ~st_q.ent[gi].mask) == '0)
                     && (lk_super ? st_q.ent[gi].sv : st_q.ent[gi].uv);
    end

    blk_ent_t sel;

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) sel = st_q.ent[i];
        end
        lk_hit    = |hv;
        lk_pa_tag = (sel.pa_tag & ~sel.mask) | (lk_tag & sel.mask);
        lk_rd     = sel.rd;
        lk_wr     = sel.wr;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ent[wr_idx] = wr_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a programmed entry holds what was written, one cycle later
    p_blk_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.ent[$past(wr_idx)] == $past(wr_ent)));

    // R4: a matching entry is valid for the privilege of the lookup
    p_priv_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_super ? (sel.sv == 1'b1) : (sel.uv == 1'b1)));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int TLB_N = 8,
    parameter int BLK_N = 4,
    localparam int BIDX_W = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_super,
    input  logic              req_store,
    output logic              rsp_valid,
    output logic [EA_W-1:0]   rsp_pa,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic              rsp_blk,
    output logic              miss_flag,
    output logic [EA_W-1:0]   miss_ea,
    input  logic              miss_clr,
    input  logic              tlb_ld_en,
    input  logic [VPN_W-1:0]  tlb_ld_vpn,
    input  logic [VPN_W-1:0]  tlb_ld_ppn,
    input  logic              tlb_ld_rd,
    input  logic              tlb_ld_wr,
    input  logic              tlb_ld_key,
    input  logic              blk_wr_en,
    input  logic [BIDX_W-1:0] blk_wr_idx,
    input  logic [BTAG_W-1:0] blk_wr_ea_tag,
    input  logic [BTAG_W-1:0] blk_wr_pa_tag,
    input  logic [BTAG_W-1:0] blk_wr_mask,
    input  logic              blk_wr_sv,
    input  logic              blk_wr_uv,
    input  logic              blk_wr_rd,
    input  logic              blk_wr_wr
);
    typedef struct packed {
        logic            rsp_valid;
        logic [EA_W-1:0] rsp_pa;
        logic            rsp_hit;
        logic            rsp_miss;
        logic            rsp_fault;
        logic            rsp_blk;
        logic            miss_flag;
        logic [EA_W-1:0] miss_ea;
    } st_t;

    st_t st_d, st_q;

    tlb_ent_t          ld_ent;
    blk_ent_t          bw_ent;
    logic              t_hit, t_rd, t_wr, t_key;
    logic [VPN_W-1:0]  t_ppn;
    logic              b_hit, b_rd, b_wr;
    logic [BTAG_W-1:0] b_pa_tag;

    always_comb begin
        ld_ent       = '0;
        ld_ent.vpn   = tlb_ld_vpn;
        ld_ent.ppn   = tlb_ld_ppn;
        ld_ent.rd    = tlb_ld_rd;
        ld_ent.wr    = tlb_ld_wr;
        ld_ent.ukey  = tlb_ld_key;
        bw_ent.sv     = blk_wr_sv;
        bw_ent.uv     = blk_wr_uv;
        bw_ent.ea_tag = blk_wr_ea_tag;
        bw_ent.pa_tag = blk_wr_pa_tag;
        bw_ent.mask   = blk_wr_mask;
        bw_ent.rd     = blk_wr_rd;
        bw_ent.wr     = blk_wr_wr;
    end

    xlat_tlb #(.N(TLB_N)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vpn  (req_ea[EA_W-1:PG_BITS]),
        .lk_hit  (t_hit),
        .lk_ppn  (t_ppn),
        .lk_rd   (t_rd),
        .lk_wr   (t_wr),
        .lk_ukey (t_key),
        .ld_en   (tlb_ld_en),
        .ld_ent  (ld_ent)
    );

    xlat_bat #(.N(BLK_N)) u_bat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (blk_wr_en),
        .wr_idx    (blk_wr_idx),
        .wr_ent    (bw_ent),
        .lk_tag    (req_ea[EA_W-1:BLK_LO]),
        .lk_super  (req_super),
        .lk_hit    (b_hit),
        .lk_pa_tag (b_pa_tag),
        .lk_rd     (b_rd),
        .lk_wr     (b_wr)
    );

    logic miss_now;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_pa    = '0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_miss  = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.rsp_blk   = 1'b0;
        miss_now       = 1'b0;
        if (req_valid) begin
            if (b_hit) begin
                if (req_store ? b_wr : b_rd) begin
                    st_d.rsp_hit = 1'b1;
                    st_d.rsp_blk = 1'b1;
                    st_d.rsp_pa  = {b_pa_tag, req_ea[BLK_LO-1:0]};
                end else begin
                    st_d.rsp_fault = 1'b1;
                end
            end else if (t_hit) begin
                if ((!req_super && t_key) || (req_store ? !t_wr : !t_rd)) begin
                    st_d.rsp_fault = 1'b1;
                end else begin
                    st_d.rsp_hit = 1'b1;
                    st_d.rsp_pa  = {t_ppn, req_ea[PG_BITS-1:0]};
                end
            end else begin
                st_d.rsp_miss = 1'b1;
                miss_now      = 1'b1;
            end
        end
        if (miss_now) begin
            st_d.miss_flag = 1'b1;
            st_d.miss_ea   = req_ea;
        end else if (miss_clr || tlb_ld_en) begin
            st_d.miss_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_pa    = st_q.rsp_pa;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_miss  = st_q.rsp_miss;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_blk   = st_q.rsp_blk;
    assign miss_flag = st_q.miss_flag;
    assign miss_ea   = st_q.miss_ea;

    // R10: one outcome per response
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R10: a response follows a request by one cycle
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R1: page offset passes through
    p_page_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_blk) |-> (rsp_pa[PG_BITS-1:0] == $past(req_ea[PG_BITS-1:0])));

    // R2: block offset passes through
    p_blk_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_blk) |-> (rsp_pa[BLK_LO-1:0] == $past(req_ea[BLK_LO-1:0])));

    // R5: no address leaks on a fault or miss
    p_zero_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_miss) |-> (rsp_pa == '0));

    // R7: a miss response comes with the captured address
    p_miss_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (miss_flag && (miss_ea == $past(req_ea))));

    // R9: the miss address moves only with a miss response
    p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_miss |-> $stable(miss_ea));
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_super = 1'b0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_blk, miss_flag;
    logic [31:0] rsp_pa, miss_ea;
    logic        miss_clr = 1'b0;
    logic        tlb_ld_en = 1'b0;
    logic [19:0] tlb_ld_vpn = '0, tlb_ld_ppn = '0;
    logic        tlb_ld_rd = 1'b0, tlb_ld_wr = 1'b0, tlb_ld_key = 1'b0;
    logic        blk_wr_en = 1'b0;
    logic [1:0]  blk_wr_idx = '0;
    logic [14:0] blk_wr_ea_tag = '0, blk_wr_pa_tag = '0, blk_wr_mask = '0;
    logic        blk_wr_sv = 1'b0, blk_wr_uv = 1'b0, blk_wr_rd = 1'b0, blk_wr_wr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ea(req_ea), .req_super(req_super), .req_store(req_store),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_blk(rsp_blk), .miss_flag(miss_flag), .miss_ea(miss_ea),
        .miss_clr(miss_clr),
        .tlb_ld_en(tlb_ld_en), .tlb_ld_vpn(tlb_ld_vpn), .tlb_ld_ppn(tlb_ld_ppn),
        .tlb_ld_rd(tlb_ld_rd), .tlb_ld_wr(tlb_ld_wr), .tlb_ld_key(tlb_ld_key),
        .blk_wr_en(blk_wr_en), .blk_wr_idx(blk_wr_idx), .blk_wr_ea_tag(blk_wr_ea_tag),
        .blk_wr_pa_tag(blk_wr_pa_tag), .blk_wr_mask(blk_wr_mask), .blk_wr_sv(blk_wr_sv),
        .blk_wr_uv(blk_wr_uv), .blk_wr_rd(blk_wr_rd), .blk_wr_wr(blk_wr_wr)
    );

    // kind: 0 hit, 1 miss, 2 fault
    typedef struct packed {
        logic [31:0] ea;
        logic        sup;
        logic        st;
        logic [1:0]  kind;
        logic        blk;
        logic [31:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0001_0345, 1'b1, 1'b0, 2'd0, 1'b0, 32'h00AB_C345, 4'd1},  // R1
        '{32'h0001_0FFF, 1'b0, 1'b1, 2'd0, 1'b0, 32'h00AB_CFFF, 4'd1},  // R1
        '{32'h0001_1010, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0012_3010, 4'd6},  // R6 supervisor ok
        '{32'h0001_1010, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0000_0000, 4'd6},  // R6 user key
        '{32'h0001_1010, 1'b1, 1'b1, 2'd2, 1'b0, 32'h0000_0000, 4'd5},  // R5 no write
        '{32'h8000_0123, 1'b0, 1'b0, 2'd0, 1'b1, 32'h1000_0123, 4'd3},  // R3 dual hit
        '{32'h8002_1234, 1'b1, 1'b0, 2'd0, 1'b1, 32'h1002_1234, 4'd2},  // R2 masked bit
        '{32'h8000_0010, 1'b1, 1'b1, 2'd2, 1'b0, 32'h0000_0000, 4'd8},  // R8 block denies
        '{32'h4000_0ABC, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0055_5ABC, 4'd4},  // R4 user falls through
        '{32'h4000_0ABC, 1'b1, 1'b1, 2'd0, 1'b1, 32'h2000_0ABC, 4'd4},  // R4 supervisor block
        '{32'h4002_0000, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0000_0000, 4'd7},  // R7
        '{32'h8004_0000, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0000, 4'd7}   // R7
    };

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp_v);
        end
    endtask

    task automatic lookup(input logic [31:0] ea, input logic sup, input logic st);
        req_valid = 1'b1; req_ea = ea; req_super = sup; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic tlb_load(input logic [19:0] vpn, input logic [19:0] ppn,
                            input logic rd, input logic wr, input logic key);
        tlb_ld_en = 1'b1; tlb_ld_vpn = vpn; tlb_ld_ppn = ppn;
        tlb_ld_rd = rd; tlb_ld_wr = wr; tlb_ld_key = key;
        @(negedge clk);
        tlb_ld_en = 1'b0;
    endtask

    task automatic blk_write(input logic [1:0] idx, input logic [14:0] et,
                             input logic [14:0] pt, input logic [14:0] m,
                             input logic sv, input logic uv, input logic rd, input logic wr);
        blk_wr_en = 1'b1; blk_wr_idx = idx; blk_wr_ea_tag = et; blk_wr_pa_tag = pt;
        blk_wr_mask = m; blk_wr_sv = sv; blk_wr_uv = uv; blk_wr_rd = rd; blk_wr_wr = wr;
        @(negedge clk);
        blk_wr_en = 1'b0;
    endtask

    task automatic expect_hit(input string rq, input logic [31:0] pa, input logic blk);
        check(rq, "hit", {31'd0, rsp_hit}, 32'd1);
        check(rq, "pa", rsp_pa, pa);
        check(rq, "blk", {31'd0, rsp_blk}, {31'd0, blk});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R12", "miss_flag", {31'd0, miss_flag}, 32'd0);
        check("R12", "miss_ea", miss_ea, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        lookup(32'h0001_0345, 1'b1, 1'b0);
        check("R12", "empty lookup miss", {31'd0, rsp_miss}, 32'd1);
        check("R7", "miss_ea", miss_ea, 32'h0001_0345);

        // program the TLB (entries 0..3) and two blocks
        tlb_load(20'h00010, 20'h00ABC, 1'b1, 1'b1, 1'b0);
        check("R9", "load clears flag", {31'd0, miss_flag}, 32'd0);
        check("R9", "load keeps miss_ea", miss_ea, 32'h0001_0345);
        tlb_load(20'h00011, 20'h00123, 1'b1, 1'b0, 1'b1);
        tlb_load(20'h80000, 20'h00777, 1'b1, 1'b1, 1'b0);
        tlb_load(20'h40000, 20'h00555, 1'b1, 1'b1, 1'b0);
        blk_write(2'd0, 15'h4000, 15'h0800, 15'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
        blk_write(2'd1, 15'h2000, 15'h1000, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] prev_ea;
            string rq;
            prev_ea = miss_ea;
            rq = $sformatf("R%0d", VEC[i].rq);
            lookup(VEC[i].ea, VEC[i].sup, VEC[i].st);
            check("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
            check(rq, "outcome", {29'd0, rsp_fault, rsp_miss, rsp_hit},
                  (VEC[i].kind == 2'd0) ? 32'd1 : (VEC[i].kind == 2'd1) ? 32'd2 : 32'd4);
            check(rq, "pa", rsp_pa, VEC[i].pa);
            check(rq, "blk", {31'd0, rsp_blk}, {31'd0, VEC[i].blk});
            if (VEC[i].kind == 2'd1) begin
                check("R7", "miss_flag", {31'd0, miss_flag}, 32'd1);
                check("R7", "miss_ea", miss_ea, VEC[i].ea);
            end else begin
                check("R9", "miss_ea held", miss_ea, prev_ea);
            end
        end

        // R10: no request, no response
        @(negedge clk);
        check("R10", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R9: clear keeps address, miss beats clear
        miss_clr = 1'b1;
        @(negedge clk);
        miss_clr = 1'b0;
        check("R9", "clr flag", {31'd0, miss_flag}, 32'd0);
        check("R9", "clr keeps ea", miss_ea, 32'h8004_0000);
        miss_clr = 1'b1;
        lookup(32'h0777_7000, 1'b1, 1'b0);
        miss_clr = 1'b0;
        check("R9", "miss beats clr", {31'd0, miss_flag}, 32'd1);
        check("R9", "race ea", miss_ea, 32'h0777_7000);
        lookup(32'h0001_0345, 1'b1, 1'b0);
        check("R9", "hit keeps ea", miss_ea, 32'h0777_7000);

        // R11: fill entries 4..7, reload in place, then evict entry 0
        for (int k = 0; k < 4; k++) tlb_load(20'h00100 + 20'(k), 20'h00A00 + 20'(k), 1'b1, 1'b1, 1'b0);
        lookup(32'h0010_1000, 1'b0, 1'b0);
        expect_hit("R11", 32'h00A0_1000, 1'b0);
        tlb_load(20'h00100, 20'h00999, 1'b1, 1'b1, 1'b0);
        lookup(32'h0010_0000, 1'b0, 1'b0);
        expect_hit("R11", 32'h0099_9000, 1'b0);
        tlb_load(20'h00200, 20'h00321, 1'b1, 1'b1, 1'b0);
        lookup(32'h0020_0ABC, 1'b0, 1'b1);
        expect_hit("R11", 32'h0032_1ABC, 1'b0);
        lookup(32'h0001_0345, 1'b1, 1'b0);
        check("R11", "oldest evicted", {31'd0, rsp_miss}, 32'd1);
        lookup(32'h0001_1010, 1'b1, 1'b0);
        expect_hit("R11", 32'h0012_3010, 1'b0);

        // R2: rewrite block 0 with no mask and write allowed
        blk_write(2'd0, 15'h4000, 15'h0003, 15'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
        lookup(32'h8000_0010, 1'b1, 1'b1);
        expect_hit("R2", 32'h0006_0010, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule